// File: doc/BRIEF.md
# Zig-zag corner transform encoder

This block turns a binary image block into a sparse map of transitional corners, one row at a time. The map suits a decoder that writes rows in alternating directions: odd rows left to right, even rows right to left. A corner bit is set wherever a pixel differs from the combined effect of its left neighbour, the pixel above it and the pixel above-left. After that, each right-to-left row is moved one place toward the left, so that a single fill rule rebuilds the image in either direction.

Rows arrive W pixels at a time on a valid/ready handshake, together with a frame-start flag. The block keeps the previous input row and the parity of the row number internally. It returns one W-bit corner row for each accepted input row, one cycle later, from a register. Each image block is encoded on its own. The frame-start flag begins a new block.

Top module: `zz_corner_enc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The first row accepted after reset is row 1, which is odd, and the row above it counts as all zeros.
- R2: Bit x of a row is column x counted from the left (bit 0 is the leftmost), and 1 means filled. Each row is padded with one empty column on each side. For an odd row, output bit x equals in[x] ^ in[x-1] ^ above[x] ^ above[x-1], where any index of -1 reads as 0.
- R3: For an even row, output bit x equals the same four-term XOR taken one column further right. Output bit W-1 therefore carries the right-padding mark, in[W-1] ^ above[W-1].
- R4: A row accepted while `frame_start` is 1 is row 1 (odd) of a new block, and the row above it counts as all zeros.
- R5: `frame_start` at 1 on a clock edge with no accepted row still clears the stored row and sets the next row to row 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_corner` and `out_valid` hold their values and `in_ready` is 0, so no input row is consumed.
- R7: A row accepted on a clock edge shows its corner row on `out_corner` with `out_valid` set after that same edge. The latency is one cycle.
- R8: Row parity alternates with every accepted row within a block.
- R9: In an all-filled block, row 1 marks only column 0, and every later row is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a new image block |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Block can accept a row |
| in_row | input | W | Pixel row, bit 0 leftmost |
| out_valid | output | 1 | Corner row present |
| out_ready | input | 1 | Downstream accepts the corner row |
| out_corner | output | W | Corner-map row, bit 0 leftmost |

## Verification
The bench sends shapes that touch the right edge on even rows. A design that drops the right-padding mark, or that never shifts, loses or misplaces bit W-1 on those rows. It sends all-filled blocks and isolated rectangles. An encoder that ignores the row above, or seeds the first row with stale data, leaves extra marks inside filled areas. It also fires frame-start on idle cycles and in the middle of a block, and holds `out_ready` low at random. A wrong parity reset or a weak stall shows up as shifted rows, lost rows or duplicated rows.

// File: rtl/zz_pkg.sv
package zz_pkg;
  typedef enum logic {DIR_L2R = 1'b0, DIR_R2L = 1'b1} dir_e;
endpackage

// File: rtl/zz_corner_mark.sv
module zz_corner_mark #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_row,
  input  logic [W-1:0] above_row,
  output logic [W:0]   marks
);
  localparam int PW = W + 2;
  logic [PW-1:0] pc, pa;

  // padded rows: bit 0 = left border, bit PW-1 = right border
  assign pc = {1'b0, cur_row, 1'b0};
  assign pa = {1'b0, above_row, 1'b0};

  // marks[k] is the transition mark at padded column k+1
  for (genvar k = 0; k <= W; k++) begin : g_mark
    assign marks[k] = pc[k+1] ^ pc[k] ^ pa[k+1] ^ pa[k];
  end
endmodule

// File: rtl/zz_dir_align.sv
module zz_dir_align
  import zz_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W:0]   marks,
  input  dir_e         dir,
  output logic [W-1:0] row_out
);
  for (genvar x = 0; x < W; x++) begin : g_sel
    assign row_out[x] = (dir == DIR_R2L) ? marks[x+1] : marks[x];
  end
endmodule

// File: rtl/zz_frame_ctrl.sv
module zz_frame_ctrl
  import zz_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         accept,
  input  logic [W-1:0] row_in,
  output logic [W-1:0] above_row,
  output dir_e         dir
);
  logic [W-1:0] prev_q;
  dir_e         dir_q;

  assign above_row = frame_start ? '0 : prev_q;
  assign dir       = frame_start ? DIR_L2R : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      dir_q  <= DIR_L2R;
    end else if (accept) begin
      prev_q <= row_in;
      dir_q  <= (dir == DIR_L2R) ? DIR_R2L : DIR_L2R;
    end else if (frame_start) begin
      prev_q <= '0;
      dir_q  <= DIR_L2R;
    end
  end

  // R8
  a_r8_parity_alternates: assert property (@(posedge clk) disable iff (rst)
    (accept && !frame_start) |=> (dir_q != $past(dir_q)));
  // R5
  a_r5_idle_start_clears: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !accept) |=> (prev_q == '0 && dir_q == DIR_L2R));
  // R4
  a_r4_start_row_odd: assert property (@(posedge clk) disable iff (rst)
    (frame_start && accept) |=> (dir_q == DIR_R2L && prev_q == $past(row_in)));
endmodule

// File: rtl/zz_corner_enc.sv
module zz_corner_enc
  import zz_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_row,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_corner
);
  logic         accept;
  logic [W-1:0] above_row;
  logic [W:0]   marks;
  logic [W-1:0] aligned;
  dir_e         dir;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  zz_frame_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .accept(accept),
    .row_in(in_row), .above_row(above_row), .dir(dir)
  );

  zz_corner_mark #(.W(W)) u_mark (
    .cur_row(in_row), .above_row(above_row), .marks(marks)
  );

  zz_dir_align #(.W(W)) u_align (
    .marks(marks), .dir(dir), .row_out(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_corner <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_corner <= aligned;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);
  // R7
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);
  // R6
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_corner)));
  // R4
  a_r4_blank_first_row: assert property (@(posedge clk) disable iff (rst)
    (accept && frame_start && in_row == '0) |=> (out_corner == '0));
endmodule

// File: tb/sim_zz_corner_enc.sv
module sim_zz_corner_enc;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_start = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_row = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_corner;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] m_prev = '0;
  logic         m_odd = 1'b1;

  always #2 clk = ~clk;

  zz_corner_enc #(.W(W)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_row(in_row), .out_valid(out_valid),
    .out_ready(out_ready), .out_corner(out_corner)
  );

  function automatic logic [W-1:0] ref_row(logic [W-1:0] cur, logic [W-1:0] up, logic odd);
    logic [W-1:0] r;
    for (int x = 0; x < W; x++) begin
      int c;
      logic a, b, u, v;
      c = odd ? x : x + 1;
      a = (c < W) ? cur[c] : 1'b0;
      b = (c > 0) ? cur[c-1] : 1'b0;
      u = (c < W) ? up[c] : 1'b0;
      v = (c > 0) ? up[c-1] : 1'b0;
      r[x] = a ^ b ^ u ^ v;
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, settle, score, then wait for the edge
  task automatic step(logic fs, logic iv, logic [W-1:0] row, logic ordy, string req);
    @(negedge clk);
    frame_start = fs; in_valid = iv; in_row = row; out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) check({req, " spurious"}, out_corner, 'x);
      else check(req, out_corner, expq.pop_front());
    end
    if (fs) begin m_prev = '0; m_odd = 1'b1; end
    if (iv && in_ready) begin
      expq.push_back(ref_row(row, m_prev, m_odd));
      m_prev = row; m_odd = ~m_odd;
    end
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, 1'b1, req);
  endtask

  initial begin
    #40000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd77));
    @(negedge clk);
    check("R1 out_valid in reset", {{(W-1){1'b0}}, out_valid}, '0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 out_valid after reset", {{(W-1){1'b0}}, out_valid}, '0);
    check("R1 in_ready after reset", {{(W-1){1'b0}}, in_ready}, {{(W-1){1'b0}}, 1'b1});

    // R9 all-filled block, no frame_start: rows after reset start odd
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, '1, 1'b1, "R9 all filled");
    drain("R9 drain");
    // R2/R3 isolated rectangle in a new frame
    step(1'b1, 1'b1, '0, 1'b1, "R4 blank first");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 16'h03C0, 1'b1, "R2 R3 rectangle");
    step(1'b0, 1'b1, '0, 1'b1, "R2 R3 rectangle bottom");
    drain("R2 drain");
    // R3 shape touching the right edge, even rows hit bit W-1
    step(1'b1, 1'b1, 16'h8000, 1'b1, "R4 right edge first");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 16'hC000, 1'b1, "R3 right edge");
    step(1'b0, 1'b1, 16'h0000, 1'b1, "R3 right edge close");
    drain("R3 drain");
    // R5 idle frame_start mid-block
    step(1'b0, 1'b1, 16'hF0F0, 1'b1, "R8 mid row");
    step(1'b1, 1'b0, '0, 1'b1, "R5 idle start");
    step(1'b0, 1'b1, 16'hF0F0, 1'b1, "R5 after idle start");
    drain("R5 drain");
    // R6 stall: output held, input refused
    step(1'b0, 1'b1, 16'h1234, 1'b0, "R6 load");
    step(1'b0, 1'b1, 16'h5678, 1'b0, "R6 stalled");
    held = out_corner;
    check("R6 in_ready low", {{(W-1){1'b0}}, in_ready}, '0);
    step(1'b0, 1'b1, 16'h5678, 1'b0, "R6 stalled");
    check("R6 held stable", out_corner, held);
    check("R7 valid held", {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, 1'b1});
    drain("R6 drain");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] r;
      r = W'($urandom);
      if ($urandom_range(0, 3) == 0) r = '0;
      step(($urandom_range(0, 19) == 0), ($urandom_range(0, 3) != 0), r,
           ($urandom_range(0, 3) != 0), "R2 R3 R7 R8 random");
    end
    drain("R7 drain");
    check("R7 no rows lost", W'(expq.size()), '0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule